// File: doc/BRIEF.md
# Isochronous Resource Manager Register Unit

This block holds the resource-manager registers of a serial-bus node: the bus manager identifier, the remaining isochronous bandwidth, the 64-bit map of free isochronous channels (kept as a high and a low quadlet), and the broadcast channel register. A transaction layer hands it one request at a time as an opcode, a byte offset, a data word and an argument word. The block answers with a response code and a result value.

Lock requests do not all behave as a plain compare-swap. The bus manager identifier uses a plain compare-swap. A bandwidth lock is read as an allocate or a free of the difference between argument and data, and it is range-checked against the register. A channel lock compares only the bits that the request flips. Channel 31, which is bit 0 of the high channel quadlet, is reserved for broadcast, and no request can ever release it. A bus-reset input puts every register back to its default value.

Each request is answered on the following clock, so two lock operations can never interleave.

Top module: `irm_reg_unit`

## Requirements
- R1: After the asynchronous reset, quadlet reads return the default register values. The byte offsets are: bus manager ID (0x21C) reads 0x3F, bandwidth (0x220) reads 4915, channels-high (0x224) reads 0xFFFFFFFE, channels-low (0x228) reads 0xFFFFFFFF, and broadcast channel (0x234) reads 0x8000001F.
- R2: A quadlet lock (opcode 2) on the bus manager ID returns the old value. It stores data[31:0] only when the old value equals arg[31:0].
- R3: A bandwidth lock with arg above 0x1FFF returns the current value and changes nothing. Otherwise only the low 13 bits of data are used.
- R4: If arg >= masked data, the lock allocates arg-data. When the register holds at least that amount, the register decreases by it and arg is returned. Otherwise the current value is returned and the register is unchanged.
- R5: If arg < masked data, the lock frees data-arg. When the sum of the current value and that amount is below 0x2000, the register takes the sum and arg is returned. Otherwise the current value is returned and the register is unchanged.
- R6: A quadlet lock on either channel quadlet computes flip = arg^data. If arg&flip equals reg&flip, the register is XORed with flip and arg is returned. Otherwise the register value is returned.
- R7: Channel 31 stays allocated. Before the rule is applied, a quadlet lock on channels-high has data bit 0 cleared, and a 64-bit lock has data bit 32 cleared.
- R8: A 64-bit lock (opcode 3) at offset 0x224 applies the R6 rule to {high, low}, using 64-bit data and arg. It returns a 64-bit result.
- R9: A quadlet write (opcode 1) to the broadcast register changes only bit 30. A quadlet lock to that register returns a type error.
- R10: A 64-bit lock at an offset whose low 2 bits are nonzero returns a type error. So does an aligned 64-bit lock at the bus manager ID, bandwidth or broadcast offsets. Any other offset except 0x224 returns an address error.
- R11: Response codes are 0 (complete), 1 (type error) and 2 (address error). Any quadlet request to an unmapped offset returns an address error. Quadlet writes to the bus manager ID, bandwidth or channel registers return a type error. Error responses carry value 0 and change no register.
- R12: Asserting bus_reset restores every R1 default on the next clock. A request presented in the same cycle is dropped without a response.
- R13: A request sampled at a clock edge gives rsp_valid high for exactly that one following cycle, with code and value. rsp_valid is low when no request was taken. Quadlet results appear on rsp_value[31:0] with the upper half zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous restore of default register values |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 quadlet lock, 3 64-bit lock |
| req_offset | input | ADDR_W | Byte offset of the target register |
| req_data | input | 64 | Write or lock data (quadlet uses [31:0]) |
| req_arg | input | 64 | Lock argument (quadlet uses [31:0]) |
| rsp_valid | output | 1 | Response strobe, one cycle per request |
| rsp_code | output | 2 | Response code |
| rsp_value | output | 64 | Read value or lock result |

## Verification
Bandwidth locks are tried with an argument out of range, an allocation that fits, one that does not, a data word with bits above the 13-bit field, and frees that stay below and reach the 0x2000 limit. These separate the masking, the range check and the two directions. Channel locks are tried with a single-bit allocate, a repeat of it that must fail, an attempt to release channel 31, and 64-bit swaps across both quadlets. These separate the flipped-bits compare from a full-word compare. Error cases cover each register with the wrong access type, misaligned 64-bit offsets, and unmapped offsets, and each is followed by readback to show that no state changed.

// File: rtl/irm_pkg.sv
package irm_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_LOCK32 = 2'd2,
    OP_LOCK64 = 2'd3
  } irm_op_e;

  typedef enum logic [1:0] {
    RC_DONE  = 2'd0,
    RC_TYPE  = 2'd1,
    RC_ADDR  = 2'd2
  } irm_rc_e;

  // Byte offsets decoded by neighbouring logic; fixed by the bus register space.
  localparam int unsigned OFF_BMID  = 32'h21C;
  localparam int unsigned OFF_BW    = 32'h220;
  localparam int unsigned OFF_CHHI  = 32'h224;
  localparam int unsigned OFF_CHLO  = 32'h228;
  localparam int unsigned OFF_BCAST = 32'h234;

  localparam logic [31:0] BMID_DEFAULT  = 32'h0000_003F;
  localparam logic [31:0] CHHI_DEFAULT  = 32'hFFFF_FFFE;
  localparam logic [31:0] CHLO_DEFAULT  = 32'hFFFF_FFFF;
  localparam logic [31:0] BCAST_DEFAULT = 32'h8000_001F;
endpackage

// File: rtl/irm_bw_lock.sv
// Bandwidth allocate/free rule, purely combinational.
module irm_bw_lock #(
  parameter int BW_W = 13,
  parameter int QW   = 32
) (
  input  logic [BW_W-1:0] cur,
  input  logic [QW-1:0]   arg,
  input  logic [QW-1:0]   data,
  output logic            upd,
  output logic [BW_W-1:0] nxt,
  output logic [QW-1:0]   ret
);
  logic            in_range;
  logic            alloc;
  logic [BW_W-1:0] a_lo;
  logic [BW_W-1:0] d_lo;
  logic [BW_W-1:0] take;
  logic [BW_W:0]   sum;

  always_comb begin
    in_range = (arg[QW-1:BW_W] == '0);
    a_lo     = arg[BW_W-1:0];
    d_lo     = data[BW_W-1:0];
    alloc    = (a_lo >= d_lo);
    take     = a_lo - d_lo;
    sum      = {1'b0, cur} + {1'b0, d_lo - a_lo};
    if (!in_range) begin
      upd = 1'b0;
    end else if (alloc) begin
      upd = (cur >= take);
    end else begin
      upd = !sum[BW_W];
    end
    nxt = alloc ? (cur - take) : sum[BW_W-1:0];
    ret = upd ? arg : {{(QW-BW_W){1'b0}}, cur};
  end
endmodule

// File: rtl/irm_chan_lock.sv
// Flipped-bits compare rule for the channel map, any width.
module irm_chan_lock #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] arg,
  input  logic [W-1:0] data,
  output logic         upd,
  output logic [W-1:0] nxt,
  output logic [W-1:0] ret
);
  logic [W-1:0] flip;

  always_comb begin
    flip = arg ^ data;
    upd  = ((arg & flip) == (cur & flip));
    nxt  = cur ^ flip;
    ret  = upd ? arg : cur;
  end
endmodule

// File: rtl/irm_reg_unit.sv
module irm_reg_unit
  import irm_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BW_W     = 13,
  parameter int BW_RESET = 4915
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [63:0]       req_data,
  input  logic [63:0]       req_arg,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [63:0]       rsp_value
);
  localparam int QW = 32;
  localparam int DW = 2 * QW;
  localparam logic [BW_W-1:0] BW_DEF = BW_W'(BW_RESET);

  logic [QW-1:0]   bmid_q, bmid_d;
  logic [BW_W-1:0] bw_q, bw_d;
  logic [QW-1:0]   ch_hi_q, ch_hi_d;
  logic [QW-1:0]   ch_lo_q, ch_lo_d;
  logic [QW-1:0]   bc_q, bc_d;
  logic            rsp_valid_q, rsp_valid_d;
  logic [1:0]      rsp_code_q, rsp_code_d;
  logic [DW-1:0]   rsp_value_q, rsp_value_d;
  logic            reg_en;

  irm_op_e op;
  logic    hit_bmid, hit_bw, hit_hi, hit_lo, hit_bc, aligned;

  assign op       = irm_op_e'(req_op);
  assign hit_bmid = (req_offset == ADDR_W'(OFF_BMID));
  assign hit_bw   = (req_offset == ADDR_W'(OFF_BW));
  assign hit_hi   = (req_offset == ADDR_W'(OFF_CHHI));
  assign hit_lo   = (req_offset == ADDR_W'(OFF_CHLO));
  assign hit_bc   = (req_offset == ADDR_W'(OFF_BCAST));
  assign aligned  = (req_offset[1:0] == 2'b00);

  // Bandwidth rule
  logic            bw_upd;
  logic [BW_W-1:0] bw_nxt;
  logic [QW-1:0]   bw_ret;
  irm_bw_lock #(.BW_W(BW_W), .QW(QW)) u_bw (
    .cur(bw_q), .arg(req_arg[QW-1:0]), .data(req_data[QW-1:0]),
    .upd(bw_upd), .nxt(bw_nxt), .ret(bw_ret)
  );

  // Quadlet channel rule: channel 31 (high bit 0) can never be released
  logic [QW-1:0] c32_cur, c32_data, c32_nxt, c32_ret;
  logic          c32_upd;
  assign c32_cur  = hit_hi ? ch_hi_q : ch_lo_q;
  assign c32_data = hit_hi ? {req_data[QW-1:1], 1'b0} : req_data[QW-1:0];
  irm_chan_lock #(.W(QW)) u_ch32 (
    .cur(c32_cur), .arg(req_arg[QW-1:0]), .data(c32_data),
    .upd(c32_upd), .nxt(c32_nxt), .ret(c32_ret)
  );

  // 64-bit channel rule over {high, low}
  logic [DW-1:0] c64_data, c64_nxt, c64_ret;
  logic          c64_upd;
  assign c64_data = {req_data[DW-1:QW+1], 1'b0, req_data[QW-1:0]};
  irm_chan_lock #(.W(DW)) u_ch64 (
    .cur({ch_hi_q, ch_lo_q}), .arg(req_arg), .data(c64_data),
    .upd(c64_upd), .nxt(c64_nxt), .ret(c64_ret)
  );

  // Next-state logic
  always_comb begin
    bmid_d      = bmid_q;
    bw_d        = bw_q;
    ch_hi_d     = ch_hi_q;
    ch_lo_d     = ch_lo_q;
    bc_d        = bc_q;
    rsp_valid_d = 1'b0;
    rsp_code_d  = RC_DONE;
    rsp_value_d = '0;
    reg_en      = bus_reset | req_valid;

    if (bus_reset) begin
      bmid_d  = BMID_DEFAULT;
      bw_d    = BW_DEF;
      ch_hi_d = CHHI_DEFAULT;
      ch_lo_d = CHLO_DEFAULT;
      bc_d    = BCAST_DEFAULT;
    end else if (req_valid) begin
      rsp_valid_d = 1'b1;
      unique case (op)
        OP_READ: begin
          if (hit_bmid)    rsp_value_d = DW'(bmid_q);
          else if (hit_bw) rsp_value_d = DW'(bw_q);
          else if (hit_hi) rsp_value_d = DW'(ch_hi_q);
          else if (hit_lo) rsp_value_d = DW'(ch_lo_q);
          else if (hit_bc) rsp_value_d = DW'(bc_q);
          else             rsp_code_d  = RC_ADDR;
        end
        OP_WRITE: begin
          if (hit_bc) bc_d = {bc_q[31], req_data[30], bc_q[29:0]};
          else if (hit_bmid || hit_bw || hit_hi || hit_lo) rsp_code_d = RC_TYPE;
          else rsp_code_d = RC_ADDR;
        end
        OP_LOCK32: begin
          if (hit_bmid) begin
            rsp_value_d = DW'(bmid_q);
            if (bmid_q == req_arg[QW-1:0]) bmid_d = req_data[QW-1:0];
          end else if (hit_bw) begin
            rsp_value_d = DW'(bw_ret);
            if (bw_upd) bw_d = bw_nxt;
          end else if (hit_hi || hit_lo) begin
            rsp_value_d = DW'(c32_ret);
            if (c32_upd && hit_hi) ch_hi_d = c32_nxt;
            if (c32_upd && hit_lo) ch_lo_d = c32_nxt;
          end else if (hit_bc) begin
            rsp_code_d = RC_TYPE;
          end else begin
            rsp_code_d = RC_ADDR;
          end
        end
        default: begin
          if (!aligned) begin
            rsp_code_d = RC_TYPE;
          end else if (hit_hi) begin
            rsp_value_d = c64_ret;
            if (c64_upd) {ch_hi_d, ch_lo_d} = c64_nxt;
          end else if (hit_bmid || hit_bw || hit_bc) begin
            rsp_code_d = RC_TYPE;
          end else begin
            rsp_code_d = RC_ADDR;
          end
        end
      endcase
    end
  end

  // Register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmid_q  <= BMID_DEFAULT;
      bw_q    <= BW_DEF;
      ch_hi_q <= CHHI_DEFAULT;
      ch_lo_q <= CHLO_DEFAULT;
      bc_q    <= BCAST_DEFAULT;
    end else if (reg_en) begin
      bmid_q  <= bmid_d;
      bw_q    <= bw_d;
      ch_hi_q <= ch_hi_d;
      ch_lo_q <= ch_lo_d;
      bc_q    <= bc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RC_DONE;
      rsp_value_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rsp_valid_d) begin
        rsp_code_q  <= rsp_code_d;
        rsp_value_q <= rsp_value_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_value = rsp_value_q;
endmodule

// File: rtl/irm_reg_unit_chk.sv
module irm_reg_unit_chk
  import irm_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BW_W     = 13,
  parameter int BW_RESET = 4915
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_reset,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_offset,
  input logic [63:0]       req_data,
  input logic [63:0]       req_arg,
  input logic              rsp_valid,
  input logic [31:0]       bmid_q,
  input logic [BW_W-1:0]   bw_q,
  input logic [31:0]       ch_hi_q,
  input logic [31:0]       ch_lo_q,
  input logic [31:0]       bc_q
);
  logic take;
  assign take = req_valid && !bus_reset;

  p_bmid_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_op == 2'd2 && req_offset == ADDR_W'(OFF_BMID) && bmid_q == req_arg[31:0])
    |=> (bmid_q == $past(req_data[31:0])));

  p_bw_range_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_op == 2'd2 && req_offset == ADDR_W'(OFF_BW) && req_arg[31:BW_W] != '0)
    |=> $stable(bw_q));

  p_chan31_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hi_q[0] == 1'b0);

  p_bcast_only_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_op == 2'd1 && req_offset == ADDR_W'(OFF_BCAST))
    |=> (bc_q[29:0] == $past(bc_q[29:0]) && bc_q[31] == $past(bc_q[31])
         && bc_q[30] == $past(req_data[30])));

  p_bus_reset_defaults_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (bmid_q == BMID_DEFAULT && bw_q == BW_W'(BW_RESET)
                   && ch_hi_q == CHHI_DEFAULT && ch_lo_q == CHLO_DEFAULT
                   && bc_q == BCAST_DEFAULT && !rsp_valid));

  p_resp_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  p_no_spurious_resp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !rsp_valid);
endmodule

bind irm_reg_unit irm_reg_unit_chk #(
  .ADDR_W(ADDR_W), .BW_W(BW_W), .BW_RESET(BW_RESET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
  .req_op(req_op), .req_offset(req_offset), .req_data(req_data),
  .req_arg(req_arg), .rsp_valid(rsp_valid), .bmid_q(bmid_q), .bw_q(bw_q),
  .ch_hi_q(ch_hi_q), .ch_lo_q(ch_lo_q), .bc_q(bc_q)
);

// File: tb/irm_reg_unit_tb.sv
module irm_reg_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_reset;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [11:0] req_offset;
  logic [63:0] req_data;
  logic [63:0] req_arg;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [63:0] rsp_value;

  irm_reg_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_op(req_op), .req_offset(req_offset), .req_data(req_data),
    .req_arg(req_arg), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_value(rsp_value)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state
  logic [31:0] m_bmid, m_bw, m_hi, m_lo, m_bc;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic m_defaults();
    m_bmid = 32'h3F; m_bw = 32'd4915; m_hi = 32'hFFFF_FFFE;
    m_lo = 32'hFFFF_FFFF; m_bc = 32'h8000_001F;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural model of one request: returns expected code and value
  task automatic model(input logic [1:0] op, input logic [11:0] off,
                       input logic [63:0] d, input logic [63:0] a,
                       output logic [1:0] code, output logic [63:0] val);
    logic [63:0] flip, cur, dd;
    int ai, di, bi;
    code = 2'd0; val = 64'd0;
    case (op)
      2'd0: begin
        if (off == 12'h21C) val = {32'd0, m_bmid};
        else if (off == 12'h220) val = {32'd0, m_bw};
        else if (off == 12'h224) val = {32'd0, m_hi};
        else if (off == 12'h228) val = {32'd0, m_lo};
        else if (off == 12'h234) val = {32'd0, m_bc};
        else code = 2'd2;
      end
      2'd1: begin
        if (off == 12'h234) m_bc[30] = d[30];
        else if (off inside {12'h21C, 12'h220, 12'h224, 12'h228}) code = 2'd1;
        else code = 2'd2;
      end
      2'd2: begin
        if (off == 12'h21C) begin
          val = {32'd0, m_bmid};
          if (m_bmid == a[31:0]) m_bmid = d[31:0];
        end else if (off == 12'h220) begin
          bi = int'(m_bw);
          if (a[31:0] > 32'h1FFF) val = {32'd0, m_bw};
          else begin
            ai = int'(a[12:0]); di = int'(d[12:0]);
            if (ai >= di) begin
              if (bi >= ai - di) begin m_bw = 32'(bi - (ai - di)); val = {32'd0, a[31:0]}; end
              else val = {32'd0, m_bw};
            end else begin
              if (bi + (di - ai) < 8192) begin m_bw = 32'(bi + (di - ai)); val = {32'd0, a[31:0]}; end
              else val = {32'd0, m_bw};
            end
          end
        end else if (off == 12'h224 || off == 12'h228) begin
          cur = {32'd0, (off == 12'h224) ? m_hi : m_lo};
          dd  = {32'd0, d[31:0]};
          if (off == 12'h224) dd[0] = 1'b0;
          flip = ({32'd0, a[31:0]} ^ dd);
          if ((a & flip) == (cur & flip)) begin
            cur = cur ^ flip; val = {32'd0, a[31:0]};
            if (off == 12'h224) m_hi = cur[31:0]; else m_lo = cur[31:0];
          end else val = cur;
        end else if (off == 12'h234) code = 2'd1;
        else code = 2'd2;
      end
      default: begin
        if (off[1:0] != 2'b00) code = 2'd1;
        else if (off == 12'h224) begin
          cur = {m_hi, m_lo}; dd = d; dd[32] = 1'b0;
          flip = a ^ dd;
          if ((a & flip) == (cur & flip)) begin
            cur = cur ^ flip; m_hi = cur[63:32]; m_lo = cur[31:0]; val = a;
          end else val = cur;
        end else if (off inside {12'h21C, 12'h220, 12'h234}) code = 2'd1;
        else code = 2'd2;
      end
    endcase
  endtask

  // Called at a falling edge; returns at the falling edge after the response.
  task automatic req(input logic [1:0] op, input logic [11:0] off,
                     input logic [63:0] d, input logic [63:0] a, input string tag);
    logic [1:0]  ecode;
    logic [63:0] eval;
    req_valid = 1'b1; req_op = op; req_offset = off; req_data = d; req_arg = a;
    model(op, off, d, a, ecode, eval);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R13 valid"}, {63'd0, rsp_valid}, 64'd1);
    check({tag, " code"}, {62'd0, rsp_code}, {62'd0, ecode});
    check({tag, " value"}, rsp_value, eval);
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0;
    @(negedge clk);
    check({tag, " R13 idle"}, {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic read_all(input string tag);
    req(2'd0, 12'h21C, 64'd0, 64'd0, {tag, " bmid"});
    req(2'd0, 12'h220, 64'd0, 64'd0, {tag, " bw"});
    req(2'd0, 12'h224, 64'd0, 64'd0, {tag, " hi"});
    req(2'd0, 12'h228, 64'd0, 64'd0, {tag, " lo"});
    req(2'd0, 12'h234, 64'd0, 64'd0, {tag, " bcast"});
  endtask

  initial begin
    rst_n = 1'b0; bus_reset = 1'b0; req_valid = 1'b0; req_op = 2'd0;
    req_offset = '0; req_data = '0; req_arg = '0;
    m_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset");
    read_all("R1 defaults");

    // R2 bus manager compare-swap
    req(2'd2, 12'h21C, 64'h05, 64'h3F, "R2 swap hit");
    req(2'd2, 12'h21C, 64'h09, 64'h3F, "R2 swap miss");
    req(2'd0, 12'h21C, 64'd0, 64'd0, "R2 readback");

    // R3 R4 R5 bandwidth
    req(2'd2, 12'h220, 64'd0, 64'h2000, "R3 arg range");
    req(2'd2, 12'h220, 64'd4815, 64'd4915, "R4 alloc fit");
    req(2'd2, 12'h220, 64'h2000 + 64'd90, 64'd100, "R3 data mask");
    req(2'd2, 12'h220, 64'd0, 64'd5000, "R4 alloc too big");
    req(2'd2, 12'h220, 64'd300, 64'd0, "R5 free fit");
    req(2'd2, 12'h220, 64'h1FFF, 64'd0, "R5 free limit");
    req(2'd0, 12'h220, 64'd0, 64'd0, "R5 readback");

    // R6 channel quadlet locks
    req(2'd2, 12'h228, 64'hFFFF_FFFE, 64'hFFFF_FFFF, "R6 lo alloc");
    req(2'd2, 12'h228, 64'hFFFF_FFFE, 64'hFFFF_FFFF, "R6 lo repeat");
    req(2'd2, 12'h224, 64'h7FFF_FFFE, 64'hFFFF_FFFE, "R6 hi alloc");
    req(2'd2, 12'h224, 64'hFFFF_FFFE, 64'h7FFF_FFFE, "R6 hi free");

    // R7 channel 31 protection
    req(2'd2, 12'h224, 64'hFFFF_FFFF, 64'hFFFF_FFFE, "R7 release q");
    req(2'd2, 12'h224, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R7 bad arg");
    req(2'd3, 12'h224, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFE_0000_0000, "R7 release 64");
    req(2'd0, 12'h224, 64'd0, 64'd0, "R7 readback");

    // R8 64-bit compare-swap
    req(2'd3, 12'h224, 64'hFFFF_FFFE_FFFF_FFF0, 64'hFFFF_FFFE_FFFF_FFFE, "R8 swap hit");
    req(2'd3, 12'h224, 64'hFFFF_FFFE_FFFF_FF00, 64'hFFFF_FFFE_FFFF_FFFE, "R8 swap miss");
    req(2'd0, 12'h228, 64'd0, 64'd0, "R8 readback");

    // R9 broadcast register
    req(2'd1, 12'h234, 64'hFFFF_FFFF, 64'd0, "R9 set valid");
    req(2'd0, 12'h234, 64'd0, 64'd0, "R9 readback set");
    req(2'd1, 12'h234, 64'h0, 64'd0, "R9 clear valid");
    req(2'd2, 12'h234, 64'h1, 64'h8000_001F, "R9 lock type");
    req(2'd0, 12'h234, 64'd0, 64'd0, "R9 readback");

    // R10 64-bit lock errors
    req(2'd3, 12'h226, 64'd0, 64'd0, "R10 misaligned");
    req(2'd3, 12'h220, 64'd0, 64'd0, "R10 bw");
    req(2'd3, 12'h21C, 64'd0, 64'd0, "R10 bmid");
    req(2'd3, 12'h234, 64'd0, 64'd0, "R10 bcast");
    req(2'd3, 12'h228, 64'd0, 64'd0, "R10 lo addr");

    // R11 quadlet errors, no side effects
    req(2'd0, 12'h300, 64'd0, 64'd0, "R11 read unmapped");
    req(2'd1, 12'h220, 64'd7, 64'd0, "R11 write bw");
    req(2'd1, 12'h21C, 64'd7, 64'd0, "R11 write bmid");
    req(2'd1, 12'h228, 64'd7, 64'd0, "R11 write lo");
    req(2'd2, 12'h300, 64'd1, 64'd0, "R11 lock unmapped");
    req(2'd1, 12'h300, 64'd1, 64'd0, "R11 write unmapped");
    read_all("R11 readback");

    // R12 bus reset with a concurrent request
    req_valid = 1'b1; req_op = 2'd2; req_offset = 12'h21C; req_data = 64'h11; req_arg = m_bmid;
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0; req_valid = 1'b0;
    m_defaults();
    check("R12 dropped rsp", {63'd0, rsp_valid}, 64'd0);
    read_all("R12 defaults");
    idle("R13 gap");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule